// File: doc/BRIEF.md
# Boot command decoder

This block sits on the write path of a flash controller's memory-mapped window. It watches 16-bit writes that land in either of two small address ranges: the boot buffer range and the boot spare range. It treats each such write as a boot-time command. Three commands are understood. The first requests a warm reset of the controller. The second writes identification bytes into the boot buffer RAM through a byte-wide write port. The third is a two-write sequence that asks the array side to load a full page into data buffer 0.

The page address register lives in this block. The host register file writes it through a plain load port. The block hands its current value, together with the current block address, to the array side as a load request, and the request is held until it is acknowledged. When the acknowledge arrives, the register steps forward by four pages, and the step wraps within the low eight bits.

The identification bytes are placed at byte offsets scaled by the register shift of the bus mapping. The cleared span is three locations wide after scaling. With a shift of one, this gives six byte writes, and zeros fill the gaps between the three identification bytes.

Top module: `bootcmd_top`

## Requirements
- R1: After synchronous reset, `rst_req`, `load_req` and `ram_we` are 0, and `page_addr`, `load_blk` and `load_page` are 0. No load sequence is armed.
- R2: A write whose word offset lies outside both 0x0000..0x01FF and 0x8000..0x800F has no effect on any output. This holds even for a command value, and also for 0x00E0, which therefore arms nothing.
- R3: A first-cycle write of 0x00F0 makes `rst_req` 1 for exactly the next cycle, and in that same cycle `page_addr` reads 0. This reset clear wins over a page write or a page advance.
- R4: A first-cycle write of 0x00E0 arms the load sequence. The next window write of 0x0000 raises `load_req` in the following cycle. `load_blk` then equals `blk_addr` and `load_page` equals `page_addr`, both as they were at that second write.
- R5: When the load sequence is armed, the next window write always disarms it. If its value is not 0x0000, no load starts and the value is not decoded as a command, so a second-cycle 0x00F0 gives no reset.
- R6: `load_req`, `load_blk` and `load_page` hold until `load_ack` is sampled high while `load_req` is 1. After that edge, `load_req` is 0 and `page_addr` becomes {8'h00, (page_addr[7:0] + 4) mod 256}.
- R7: While a load is pending, the boot writes are still decoded, but a completed load sequence starts no second load and leaves `load_blk` and `load_page` unchanged.
- R8: A first-cycle write of 0x0090 produces `ram_we` for 3<<REG_SHIFT consecutive cycles, starting the next cycle. `ram_addr` counts 0,1,2,… in that run. `ram_wdata` is `man_id[7:0]` at address 0, `dev_id[7:0]` at 1<<REG_SHIFT, `wp_status[7:0]` at 2<<REG_SHIFT, and 0 at every other address. The three ID values are the ones present at the command write.
- R9: Any other first-cycle value is ignored, and it does not arm the load sequence.
- R10: `page_wr_en` loads `page_addr` with the full 16-bit `page_wr_data` on the next edge. A page write wins over a page advance in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Bus write strobe |
| wr_addr | input | ADDR_W | Word offset of the write |
| wr_data | input | 16 | Write data |
| man_id | input | 16 | Manufacturer identification value |
| dev_id | input | 16 | Device identification value |
| wp_status | input | 16 | Current write-protection status |
| blk_addr | input | 16 | Current block address register |
| page_wr_en | input | 1 | Host write to the page address register |
| page_wr_data | input | 16 | Value for the page address register |
| load_ack | input | 1 | Array side has finished the page load |
| rst_req | output | 1 | One-cycle warm reset request |
| load_req | output | 1 | Page load request, held until acknowledged |
| load_blk | output | 16 | Block address of the pending load |
| load_page | output | 16 | Page address of the pending load |
| page_addr | output | 16 | Page address register |
| ram_we | output | 1 | Boot buffer RAM byte write enable |
| ram_addr | output | RAM_AW | Boot buffer RAM byte address |
| ram_wdata | output | 8 | Boot buffer RAM byte data |

## Verification
The bench builds the block with REG_SHIFT = 1, so each identification run is six writes long. Zero bytes fall between the three ID bytes, and this exposes any mistake in offset scaling or in the extent of the clear. PAGE_STEP = 4 with an 8-bit wrap lets a directed load started from page 0x00FC reach the wrap to 0x0000 in one acknowledge. The default window bounds let random addresses sit right at the edges 0x01FF/0x0200 and 0x800F/0x8010. The random phase overlaps resets, ID runs and pending loads, and it places page writes and acknowledges in the same cycle.

// File: rtl/bootcmd_pkg.sv
package bootcmd_pkg;
  localparam int WORD_W = 16;
  typedef logic [WORD_W-1:0] word_t;

  localparam word_t CODE_WARM_RESET = 16'h00F0;
  localparam word_t CODE_LOAD_ARM   = 16'h00E0;
  localparam word_t CODE_IDENTIFY   = 16'h0090;
  localparam word_t CODE_LOAD_GO    = 16'h0000;
endpackage

// File: rtl/bootcmd_window.sv
module bootcmd_window #(
  parameter int ADDR_W    = 16,
  parameter int BUF_BASE  = 16'h0000,
  parameter int BUF_WORDS = 16'h0200,
  parameter int SPR_BASE  = 16'h8000,
  parameter int SPR_WORDS = 16'h0010
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  output logic              hit
);
  localparam logic [ADDR_W-1:0] BUF_B = ADDR_W'(BUF_BASE);
  localparam logic [ADDR_W-1:0] BUF_N = ADDR_W'(BUF_WORDS);
  localparam logic [ADDR_W-1:0] SPR_B = ADDR_W'(SPR_BASE);
  localparam logic [ADDR_W-1:0] SPR_N = ADDR_W'(SPR_WORDS);

  logic [ADDR_W-1:0] buf_off, spr_off;

  always_comb begin
    buf_off = wr_addr - BUF_B;
    spr_off = wr_addr - SPR_B;
    hit     = wr_en && ((buf_off < BUF_N) || (spr_off < SPR_N));
  end
endmodule

// File: rtl/bootcmd_phase.sv
module bootcmd_phase
  import bootcmd_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  hit,
  input  word_t wr_data,
  output logic  cmd_reset,
  output logic  cmd_ident,
  output logic  load_go,
  output logic  rst_req
);
  logic armed_q;
  logic first_cyc;

  always_comb begin
    first_cyc = hit && !armed_q;
    cmd_reset = first_cyc && (wr_data == CODE_WARM_RESET);
    cmd_ident = first_cyc && (wr_data == CODE_IDENTIFY);
    load_go   = hit && armed_q && (wr_data == CODE_LOAD_GO);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q <= 1'b0;
      rst_req <= 1'b0;
    end else begin
      rst_req <= cmd_reset;
      if (hit) armed_q <= first_cyc && (wr_data == CODE_LOAD_ARM);
    end
  end

  // R5
  disarm_on_second_chk: assert property (@(posedge clk) disable iff (rst)
    (armed_q && hit) |=> !armed_q);

  // R5
  no_reset_when_armed_chk: assert property (@(posedge clk) disable iff (rst)
    armed_q |=> !rst_req);
endmodule

// File: rtl/bootcmd_loadctl.sv
module bootcmd_loadctl
  import bootcmd_pkg::*;
#(
  parameter int PAGE_STEP   = 4,
  parameter int PAGE_KEEP_W = 8
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  cmd_reset,
  input  logic  load_go,
  input  word_t blk_addr,
  input  logic  page_wr_en,
  input  word_t page_wr_data,
  input  logic  load_ack,
  output logic  load_req,
  output word_t load_blk,
  output word_t load_page,
  output word_t page_addr
);
  localparam int HI_W = WORD_W - PAGE_KEEP_W;

  logic advance;
  logic [PAGE_KEEP_W-1:0] page_low_next;

  always_comb begin
    advance       = load_req && load_ack;
    page_low_next = page_addr[PAGE_KEEP_W-1:0] + PAGE_KEEP_W'(PAGE_STEP);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      load_req  <= 1'b0;
      load_blk  <= '0;
      load_page <= '0;
    end else if (load_go && !load_req) begin
      load_req  <= 1'b1;
      load_blk  <= blk_addr;
      load_page <= page_addr;
    end else if (advance) begin
      load_req  <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || cmd_reset)  page_addr <= '0;
    else if (page_wr_en)   page_addr <= page_wr_data;
    else if (advance)      page_addr <= {{HI_W{1'b0}}, page_low_next};
  end

  // R6
  load_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (load_req && !load_ack) |=> (load_req && $stable(load_blk) && $stable(load_page)));

  // R6
  load_release_chk: assert property (@(posedge clk) disable iff (rst)
    (load_req && load_ack) |=> !load_req);

  // R6
  page_step_chk: assert property (@(posedge clk) disable iff (rst)
    (load_req && load_ack && !page_wr_en && !cmd_reset) |=>
      (page_addr[PAGE_KEEP_W-1:0] == $past(page_addr[PAGE_KEEP_W-1:0]) + PAGE_KEEP_W'(PAGE_STEP)));

  // R7
  pending_blocks_new_chk: assert property (@(posedge clk) disable iff (rst)
    (load_req && !load_ack) |=> $stable(load_page));
endmodule

// File: rtl/bootcmd_idseq.sv
module bootcmd_idseq
  import bootcmd_pkg::*;
#(
  parameter int REG_SHIFT = 1,
  parameter int RAM_AW    = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  word_t             man_id,
  input  word_t             dev_id,
  input  word_t             wp_status,
  output logic              ram_we,
  output logic [RAM_AW-1:0] ram_addr,
  output logic [7:0]        ram_wdata
);
  localparam int ID_LEN = 3 << REG_SHIFT;
  localparam logic [RAM_AW-1:0] LAST_A = RAM_AW'(ID_LEN - 1);
  localparam logic [RAM_AW-1:0] DEV_A  = RAM_AW'(1 << REG_SHIFT);
  localparam logic [RAM_AW-1:0] WP_A   = RAM_AW'(2 << REG_SHIFT);

  logic [7:0] dev_b, wp_b;
  logic [RAM_AW-1:0] nxt_a;
  logic [7:0] nxt_d;

  always_comb begin
    nxt_a = ram_addr + 1'b1;
    if (nxt_a == DEV_A)     nxt_d = dev_b;
    else if (nxt_a == WP_A) nxt_d = wp_b;
    else                    nxt_d = 8'h00;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ram_we    <= 1'b0;
      ram_addr  <= '0;
      ram_wdata <= 8'h00;
      dev_b     <= 8'h00;
      wp_b      <= 8'h00;
    end else if (start) begin
      ram_we    <= 1'b1;
      ram_addr  <= '0;
      ram_wdata <= man_id[7:0];
      dev_b     <= dev_id[7:0];
      wp_b      <= wp_status[7:0];
    end else if (ram_we) begin
      if (ram_addr == LAST_A) begin
        ram_we    <= 1'b0;
        ram_addr  <= '0;
        ram_wdata <= 8'h00;
      end else begin
        ram_addr  <= nxt_a;
        ram_wdata <= nxt_d;
      end
    end
  end

  // R8
  id_range_chk: assert property (@(posedge clk) disable iff (rst)
    ram_we |-> (ram_addr <= LAST_A));

  // R8
  id_ascend_chk: assert property (@(posedge clk) disable iff (rst)
    (ram_we && ram_addr != '0) |-> ($past(ram_we) && ram_addr == $past(ram_addr) + 1'b1));
endmodule

// File: rtl/bootcmd_top.sv
module bootcmd_top
  import bootcmd_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int BUF_BASE    = 16'h0000,
  parameter int BUF_WORDS   = 16'h0200,
  parameter int SPR_BASE    = 16'h8000,
  parameter int SPR_WORDS   = 16'h0010,
  parameter int REG_SHIFT   = 1,
  parameter int RAM_AW      = 10,
  parameter int PAGE_STEP   = 4,
  parameter int PAGE_KEEP_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [15:0]       wr_data,
  input  logic [15:0]       man_id,
  input  logic [15:0]       dev_id,
  input  logic [15:0]       wp_status,
  input  logic [15:0]       blk_addr,
  input  logic              page_wr_en,
  input  logic [15:0]       page_wr_data,
  input  logic              load_ack,
  output logic              rst_req,
  output logic              load_req,
  output logic [15:0]       load_blk,
  output logic [15:0]       load_page,
  output logic [15:0]       page_addr,
  output logic              ram_we,
  output logic [RAM_AW-1:0] ram_addr,
  output logic [7:0]        ram_wdata
);
  logic hit, cmd_reset, cmd_ident, load_go;

  bootcmd_window #(
    .ADDR_W(ADDR_W), .BUF_BASE(BUF_BASE), .BUF_WORDS(BUF_WORDS),
    .SPR_BASE(SPR_BASE), .SPR_WORDS(SPR_WORDS)
  ) win_i (
    .wr_en(wr_en), .wr_addr(wr_addr), .hit(hit)
  );

  bootcmd_phase phase_i (
    .clk(clk), .rst(rst), .hit(hit), .wr_data(wr_data),
    .cmd_reset(cmd_reset), .cmd_ident(cmd_ident), .load_go(load_go),
    .rst_req(rst_req)
  );

  bootcmd_loadctl #(.PAGE_STEP(PAGE_STEP), .PAGE_KEEP_W(PAGE_KEEP_W)) load_i (
    .clk(clk), .rst(rst), .cmd_reset(cmd_reset), .load_go(load_go),
    .blk_addr(blk_addr), .page_wr_en(page_wr_en), .page_wr_data(page_wr_data),
    .load_ack(load_ack), .load_req(load_req), .load_blk(load_blk),
    .load_page(load_page), .page_addr(page_addr)
  );

  bootcmd_idseq #(.REG_SHIFT(REG_SHIFT), .RAM_AW(RAM_AW)) id_i (
    .clk(clk), .rst(rst), .start(cmd_ident), .man_id(man_id),
    .dev_id(dev_id), .wp_status(wp_status), .ram_we(ram_we),
    .ram_addr(ram_addr), .ram_wdata(ram_wdata)
  );

  // R3
  reset_clears_page_chk: assert property (@(posedge clk) disable iff (rst)
    rst_req |-> (page_addr == '0));

  // R2
  outside_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!hit) |=> !rst_req);
endmodule

// File: tb/bootcmd_top_tb_top.sv
module bootcmd_top_tb_top;
  localparam int N_ID = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [15:0] wr_addr = '0, wr_data = '0;
  logic [15:0] man_id = 16'h11AB, dev_id = 16'h22CD, wp_status = 16'h0002;
  logic [15:0] blk_addr = '0, page_wr_data = '0;
  logic page_wr_en = 1'b0, load_ack = 1'b0;
  logic rst_req, load_req, ram_we;
  logic [15:0] load_blk, load_page, page_addr;
  logic [9:0] ram_addr;
  logic [7:0] ram_wdata;

  int checks = 0, fails = 0;
  bit done = 0;

  // model state
  bit m_armed, m_rst, m_pend, m_we;
  logic [15:0] m_blk, m_lpage, m_page;
  int m_addr;
  logic [7:0] m_man, m_dev, m_wp;

  always #4 clk = ~clk;

  bootcmd_top dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .man_id(man_id), .dev_id(dev_id), .wp_status(wp_status), .blk_addr(blk_addr),
    .page_wr_en(page_wr_en), .page_wr_data(page_wr_data), .load_ack(load_ack),
    .rst_req(rst_req), .load_req(load_req), .load_blk(load_blk),
    .load_page(load_page), .page_addr(page_addr), .ram_we(ram_we),
    .ram_addr(ram_addr), .ram_wdata(ram_wdata)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] id_byte(int a, logic [7:0] m, logic [7:0] d, logic [7:0] w);
    if (a == 0) return m;
    if (a == 2) return d;
    if (a == 4) return w;
    return 8'h00;
  endfunction

  function automatic bit in_window(logic [15:0] a);
    return (a <= 16'h01FF) || (a >= 16'h8000 && a <= 16'h800F);
  endfunction

  task automatic model_step();
    bit hit, first;
    logic [15:0] old_page;
    old_page = m_page;
    if (rst) begin
      m_armed = 0; m_rst = 0; m_pend = 0; m_we = 0; m_addr = 0;
      m_blk = 0; m_lpage = 0; m_page = 0;
      return;
    end
    hit = wr_en && in_window(wr_addr);
    first = hit && !m_armed;
    m_rst = first && wr_data == 16'h00F0;
    if (m_rst) m_page = 0;
    else if (page_wr_en) m_page = page_wr_data;
    else if (m_pend && load_ack) m_page = {8'h00, old_page[7:0] + 8'd4};
    if (hit && m_armed && wr_data == 16'h0000 && !m_pend) begin
      m_pend = 1; m_blk = blk_addr; m_lpage = old_page;
    end else if (m_pend && load_ack) m_pend = 0;
    if (hit) m_armed = first && wr_data == 16'h00E0;
    if (first && wr_data == 16'h0090) begin
      m_we = 1; m_addr = 0;
      m_man = man_id[7:0]; m_dev = dev_id[7:0]; m_wp = wp_status[7:0];
    end else if (m_we) begin
      if (m_addr == N_ID - 1) m_we = 0; else m_addr++;
    end
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    #1;
    if (!rst) begin
      chk("R3", "rst_req", rst_req, m_rst);
      chk("R6", "load_req", load_req, m_pend);
      if (m_pend) begin
        chk("R4", "load_blk", load_blk, m_blk);
        chk("R4", "load_page", load_page, m_lpage);
      end
      chk("R10", "page_addr", page_addr, m_page);
      chk("R8", "ram_we", ram_we, m_we);
      if (m_we) begin
        chk("R8", "ram_addr", ram_addr, m_addr);
        chk("R8", "ram_wdata", ram_wdata, id_byte(m_addr, m_man, m_dev, m_wp));
      end
    end
  endtask

  task automatic wr(logic [15:0] a, logic [15:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    tick();
    wr_en = 0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst = 1;
    repeat (3) tick();
    rst = 0;
    tick();
    // R1 reset state
    chk("R1", "rst_req", rst_req, 0);
    chk("R1", "load_req", load_req, 0);
    chk("R1", "ram_we", ram_we, 0);
    chk("R1", "page_addr", page_addr, 0);
    chk("R1", "load_blk", load_blk, 0);
    chk("R1", "load_page", load_page, 0);

    // R2 outside the window
    wr(16'h0200, 16'h00F0); chk("R2", "rst_req at 0x0200", rst_req, 0);
    wr(16'h8010, 16'h00F0); chk("R2", "rst_req at 0x8010", rst_req, 0);
    wr(16'h7FFF, 16'h00E0);
    wr(16'h0000, 16'h0000); chk("R2", "load_req after outside arm", load_req, 0);

    // R9 unknown first-cycle value
    wr(16'h0001, 16'h1234);
    chk("R9", "rst_req", rst_req, 0);
    chk("R9", "ram_we", ram_we, 0);
    wr(16'h0001, 16'h0000); chk("R9", "load_req", load_req, 0);

    // R10 page write
    page_wr_en = 1; page_wr_data = 16'h1234; tick(); page_wr_en = 0;
    chk("R10", "page_addr", page_addr, 16'h1234);

    // R3 warm reset
    wr(16'h01FF, 16'h00F0);
    chk("R3", "rst_req", rst_req, 1);
    chk("R3", "page_addr", page_addr, 0);
    tick(); chk("R3", "rst_req one cycle", rst_req, 0);

    // R5 second cycle not zero
    wr(16'h0010, 16'h00E0);
    wr(16'h0011, 16'h00F0); chk("R5", "rst_req on second cycle", rst_req, 0);
    wr(16'h0012, 16'h0000); chk("R5", "load_req after disarm", load_req, 0);

    // R4 load sequence
    page_wr_en = 1; page_wr_data = 16'h00FC; tick(); page_wr_en = 0;
    blk_addr = 16'h0ABC;
    wr(16'h8003, 16'h00E0);
    wr(16'h0100, 16'h0000);
    chk("R4", "load_req", load_req, 1);
    chk("R4", "load_blk", load_blk, 16'h0ABC);
    chk("R4", "load_page", load_page, 16'h00FC);
    blk_addr = 16'h0555;

    // R7 second load dropped, ID still decoded
    wr(16'h0000, 16'h00E0);
    wr(16'h0000, 16'h0000);
    chk("R7", "load_req", load_req, 1);
    chk("R7", "load_blk", load_blk, 16'h0ABC);
    chk("R7", "load_page", load_page, 16'h00FC);
    wr(16'h800F, 16'h0090);
    chk("R7", "ram_we while pending", ram_we, 1);
    // R8 identification bytes
    chk("R8", "byte0", ram_wdata, 8'hAB);
    for (int i = 1; i < N_ID; i++) begin
      tick();
      chk("R8", "addr", ram_addr, i);
      chk("R8", "data", ram_wdata, id_byte(i, 8'hAB, 8'hCD, 8'h02));
    end
    tick(); chk("R8", "ram_we end", ram_we, 0);
    chk("R6", "load_req still held", load_req, 1);

    // R6 acknowledge and wrap
    load_ack = 1; tick(); load_ack = 0;
    chk("R6", "load_req released", load_req, 0);
    chk("R6", "page wrap", page_addr, 16'h0000);
    wr(16'h0002, 16'h00E0); wr(16'h0003, 16'h0000);
    load_ack = 1; tick(); load_ack = 0;
    chk("R6", "page step", page_addr, 16'h0004);

    // R10 page write beats advance
    wr(16'h0002, 16'h00E0); wr(16'h0003, 16'h0000);
    load_ack = 1; page_wr_en = 1; page_wr_data = 16'h0040; tick();
    load_ack = 0; page_wr_en = 0;
    chk("R10", "write wins", page_addr, 16'h0040);
    chk("R6", "load_req released", load_req, 0);

    // random phase
    for (int c = 0; c < 6000; c++) begin
      int sel;
      wr_en = ($urandom % 2) == 0;
      sel = $urandom % 4;
      case (sel)
        0: wr_addr = 16'($urandom % 16'h0200);
        1: wr_addr = 16'h8000 + 16'($urandom % 16);
        2: wr_addr = ($urandom % 2) ? 16'h0200 : 16'h8010;
        default: wr_addr = 16'($urandom);
      endcase
      sel = $urandom % 10;
      case (sel)
        0: wr_data = 16'h00F0;
        1, 2: wr_data = 16'h00E0;
        3: wr_data = 16'h0090;
        4, 5, 6: wr_data = 16'h0000;
        default: wr_data = 16'($urandom);
      endcase
      load_ack = ($urandom % 5) < 2;
      page_wr_en = ($urandom % 30) == 0;
      page_wr_data = 16'($urandom);
      blk_addr = 16'($urandom);
      man_id = 16'($urandom); dev_id = 16'($urandom); wp_status = 16'($urandom);
      tick();
    end
    done = 1;
    finish_run();
  end
endmodule